// File: doc/BRIEF.md
# PCI Host Bridge Memory Window Mapping Registers

This block is the 32-bit control register file of a PCI host bridge. It holds eight registers: three window mapping registers, three secondary mapping registers, one self-identifier register and one flags register. Software reaches them over a simple register bus. The bus has an address, a write strobe, a read strobe, write data, registered read data and a registered error flag.

The block has three local memory windows, each of a fixed size. Each window is turned into a PCI bus address through its own mapping register. The meaning of a mapping register depends on the board-variant strap `cfg_rv`:

- With `cfg_rv` = 0 (nibble variant), the low four bits of the register give the top four bits of the PCI address.
- With `cfg_rv` = 1 (masked variant), the register's upper bits give the upper address bits, after masking to the window size.

The window sizes also depend on the variant. A translation port takes a window index and a local offset and returns the PCI address one cycle later. It raises an error for an unknown window or an offset past the end of the window.

Top module: `pcib_winmap_regs`

## Requirements
- R1: Registers are at these byte offsets: window maps 0, 1 and 2 at 0x00, 0x04 and 0x08; self-identifier at 0x0C; flags at 0x10; secondary maps 0, 1 and 2 at 0x14, 0x18 and 0x1C. A write stores all 32 bits. A read strobe in one cycle returns the value in `reg_rdata` on the next cycle, with `reg_err` low.
- R2: After reset all eight registers read as zero, and `xl_vld`, `xl_err` and `reg_err` are low.
- R3: Only aligned 32-bit accesses to the eight listed offsets are valid. For any other address, or any address with bits [1:0] not zero, the access is invalid. An invalid write changes no register. An invalid read returns zero. Either kind of invalid access sets `reg_err` high in the following cycle.
- R4: With `cfg_rv` = 0, a window's PCI base is its mapping register shifted left by 28 bits, so register bits [3:0] become address bits [31:28]. The result is base plus offset.
- R5: With `cfg_rv` = 1, a window's PCI base is its mapping register ANDed with the inverse of (window size − 1). The result is base plus offset.
- R6: Window sizes are 0x0C000000, 0x10000000 and 0x10000000 when `cfg_rv` = 0, and 0x01000000, 0x04000000 and 0x08000000 when `cfg_rv` = 1. An offset equal to or above the selected window's size gives `xl_err` = 1 with `xl_addr` = 0.
- R7: Window index 3 gives `xl_err` = 1 with `xl_addr` = 0.
- R8: A request with `xl_req` high in one cycle yields `xl_vld` high with its result in the next cycle. Only then is `xl_vld` high. A request in the cycle after a mapping write uses the new value. A request in the same cycle as the write uses the old value.
- R9: Writes to the secondary maps, the self-identifier and the flags registers do not change any translation result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rv | input | 1 | Board variant: 0 nibble-select, 1 size-masked |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| reg_err | output | 1 | Invalid access, one cycle after the strobe |
| xl_req | input | 1 | Translation request |
| xl_win | input | 2 | Window index |
| xl_ofs | input | 28 | Local offset within the window |
| xl_vld | output | 1 | Translation result valid |
| xl_addr | output | 32 | Translated PCI address |
| xl_err | output | 1 | Translation error (bad window or offset) |

## Verification
The translation port is tried in both variants with mapping values that fill every bit. This separates the 4-bit nibble use of the register from the size-masked use, and it shows the masking clearing different low bits for each of the three window sizes.

Offsets are tried at zero, at exactly size − 1 and at exactly the size. These show that the range compare uses the correct per-variant size and is exclusive at the top.

A mapping write issued in the same cycle as a request, and again one cycle before a request, separates the old value from the new one. A final set of writes to the non-mapping registers must leave the translated addresses unchanged.

// File: rtl/pcib_wm_pkg.sv
package pcib_wm_pkg;

  localparam int unsigned NUM_WIN  = 3;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned WSEL_W   = $clog2(NUM_REGS);

  // Word index inside the register region; the order sets the byte offsets.
  typedef enum logic [WSEL_W-1:0] {
    RW_MAP0  = 3'd0,
    RW_MAP1  = 3'd1,
    RW_MAP2  = 3'd2,
    RW_IDENT = 3'd3,
    RW_FLAGS = 3'd4,
    RW_SEC0  = 3'd5,
    RW_SEC1  = 3'd6,
    RW_SEC2  = 3'd7
  } reg_word_e;

endpackage

// File: rtl/pcib_wm_decode.sv
module pcib_wm_decode
  import pcib_wm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [WSEL_W-1:0] wsel
);

  localparam int unsigned HI_LSB = WSEL_W + 2;

  logic aligned;
  logic in_region;

  assign aligned   = (addr[1:0] == 2'b00);
  assign in_region = (addr[ADDR_W-1:HI_LSB] == '0);
  assign hit       = aligned && in_region;
  assign wsel      = addr[HI_LSB-1:2];

endmodule

// File: rtl/pcib_wm_regbank.sv
module pcib_wm_regbank
  import pcib_wm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [DATA_W-1:0]                bus_rdata,
  output logic                             bus_err,
  output logic [NUM_WIN-1:0][DATA_W-1:0]   map_o
);

  logic              hit;
  logic [WSEL_W-1:0] wsel;
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  pcib_wm_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (bus_addr),
    .hit  (hit),
    .wsel (wsel)
  );

  // One storage register per word; each has its own write enable.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic we;
    assign we = bus_wr && hit && (wsel == WSEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[i] <= '0;
      end else if (we) begin
        regs_q[i] <= bus_wdata;
      end
    end
  end

  // Registered read port and access-error flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= (bus_wr || bus_rd) && !hit;
      if (bus_rd) begin
        bus_rdata <= hit ? regs_q[wsel] : '0;
      end
    end
  end

  // Window mapping registers feed the translation unit.
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_map
    assign map_o[w] = regs_q[int'(RW_MAP0) + w];
  end

endmodule

// File: rtl/pcib_wm_xlat.sv
module pcib_wm_xlat
  import pcib_wm_pkg::*;
#(
  parameter int unsigned              DATA_W   = 32,
  parameter int unsigned              OFS_W    = 28,
  parameter logic [NUM_WIN*32-1:0]    VP_SIZES = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
  parameter logic [NUM_WIN*32-1:0]    RV_SIZES = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_rv,
  input  logic [NUM_WIN-1:0][DATA_W-1:0] map_i,
  input  logic                           req,
  input  logic [1:0]                     win,
  input  logic [OFS_W-1:0]               ofs,
  output logic                           vld_o,
  output logic [DATA_W-1:0]              addr_o,
  output logic                           err_o
);

  localparam int unsigned NIB_LSB = DATA_W - 4;
  localparam int unsigned IDX_N   = 4;

  logic [DATA_W-1:0] size_tbl [IDX_N];
  logic [DATA_W-1:0] base_tbl [IDX_N];

  // Per-window size and base; unused index slots read as zero size.
  for (genvar w = 0; w < IDX_N; w++) begin : g_win
    if (w < NUM_WIN) begin : g_real
      logic [DATA_W-1:0] sz;
      logic [DATA_W-1:0] nib_base;
      logic [DATA_W-1:0] msk_base;
      assign sz       = cfg_rv ? DATA_W'(RV_SIZES[w*32 +: 32])
                               : DATA_W'(VP_SIZES[w*32 +: 32]);
      assign nib_base = {map_i[w][3:0], {NIB_LSB{1'b0}}};
      assign msk_base = map_i[w] & ~(sz - DATA_W'(1));
      assign size_tbl[w] = sz;
      assign base_tbl[w] = cfg_rv ? msk_base : nib_base;
    end else begin : g_none
      assign size_tbl[w] = '0;
      assign base_tbl[w] = '0;
    end
  end

  logic [DATA_W-1:0] ofs_ext;
  logic [DATA_W-1:0] sel_size;
  logic [DATA_W-1:0] sum;
  logic              bad;

  assign ofs_ext  = DATA_W'(ofs);
  assign sel_size = size_tbl[win];
  assign sum      = base_tbl[win] + ofs_ext;
  assign bad      = (32'(win) >= NUM_WIN) || (ofs_ext >= sel_size);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      vld_o <= req;
      if (req) begin
        err_o  <= bad;
        addr_o <= bad ? '0 : sum;
      end else begin
        err_o  <= 1'b0;
        addr_o <= '0;
      end
    end
  end

endmodule

// File: rtl/pcib_winmap_regs.sv
module pcib_winmap_regs
  import pcib_wm_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 12,
  parameter int unsigned           DATA_W   = 32,
  parameter int unsigned           OFS_W    = 28,
  parameter logic [NUM_WIN*32-1:0] VP_SIZES = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
  parameter logic [NUM_WIN*32-1:0] RV_SIZES = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rv,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_err,
  input  logic              xl_req,
  input  logic [1:0]        xl_win,
  input  logic [OFS_W-1:0]  xl_ofs,
  output logic              xl_vld,
  output logic [DATA_W-1:0] xl_addr,
  output logic              xl_err
);

  logic [NUM_WIN-1:0][DATA_W-1:0] map_w;

  pcib_wm_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (reg_addr),
    .bus_wr    (reg_wr),
    .bus_rd    (reg_rd),
    .bus_wdata (reg_wdata),
    .bus_rdata (reg_rdata),
    .bus_err   (reg_err),
    .map_o     (map_w)
  );

  pcib_wm_xlat #(
    .DATA_W   (DATA_W),
    .OFS_W    (OFS_W),
    .VP_SIZES (VP_SIZES),
    .RV_SIZES (RV_SIZES)
  ) xlat_i (
    .clk    (clk),
    .rst    (rst),
    .cfg_rv (cfg_rv),
    .map_i  (map_w),
    .req    (xl_req),
    .win    (xl_win),
    .ofs    (xl_ofs),
    .vld_o  (xl_vld),
    .addr_o (xl_addr),
    .err_o  (xl_err)
  );

endmodule

// File: rtl/pcib_wm_chk.sv
module pcib_wm_chk
  import pcib_wm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic                           clk,
  input logic                           rst,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic                           reg_wr,
  input logic                           reg_rd,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic                           reg_err,
  input logic                           xl_req,
  input logic [1:0]                     xl_win,
  input logic                           xl_vld,
  input logic [DATA_W-1:0]              xl_addr,
  input logic                           xl_err,
  input logic [NUM_WIN-1:0][DATA_W-1:0] map_w
);

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr[1:0] != 2'b00) |=> (reg_rdata == '0 && reg_err)); // R3

  AST_MISALIGNED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr[1:0] != 2'b00) |=> $stable(map_w)); // R3

  AST_MAP_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(map_w)); // R1

  AST_WINDOW3_FAULT: assert property (@(posedge clk) disable iff (rst)
    (xl_req && xl_win == 2'd3) |=> (xl_err && xl_addr == '0)); // R7

  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    xl_req |=> xl_vld); // R8

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
    !xl_req |=> !xl_vld); // R8

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    xl_err |-> (xl_addr == '0 && xl_vld)); // R6

endmodule

bind pcib_winmap_regs pcib_wm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .reg_err   (reg_err),
  .xl_req    (xl_req),
  .xl_win    (xl_win),
  .xl_vld    (xl_vld),
  .xl_addr   (xl_addr),
  .xl_err    (xl_err),
  .map_w     (map_w)
);

// File: tb/pcib_winmap_regs_tb_top.sv
module pcib_winmap_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_rv = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        xl_req = 1'b0;
  logic [1:0]  xl_win = '0;
  logic [27:0] xl_ofs = '0;
  logic        xl_vld;
  logic [31:0] xl_addr;
  logic        xl_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pcib_winmap_regs dut_i (
    .clk(clk), .rst(rst), .cfg_rv(cfg_rv),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .xl_req(xl_req), .xl_win(xl_win), .xl_ofs(xl_ofs),
    .xl_vld(xl_vld), .xl_addr(xl_addr), .xl_err(xl_err)
  );

  // Shadow of the mapping registers, kept from the bench's own writes.
  logic [31:0] shadow [3];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] win_size(input bit rv, input int w);
    case ({rv, 2'(w)})
      3'b000: return 32'h0C00_0000;
      3'b001: return 32'h1000_0000;
      3'b010: return 32'h1000_0000;
      3'b100: return 32'h0100_0000;
      3'b101: return 32'h0400_0000;
      3'b110: return 32'h0800_0000;
      default: return 32'h0;
    endcase
  endfunction

  // Returns {error, address} as the requirements define it.
  function automatic logic [32:0] expect_xl(input bit rv, input int w, input logic [31:0] ofs);
    logic [31:0] sz, base;
    if (w >= 3) return {1'b1, 32'h0};
    sz = win_size(rv, w);
    if (ofs >= sz) return {1'b1, 32'h0};
    base = rv ? (shadow[w] & ~(sz - 32'd1)) : {shadow[w][3:0], 28'h0};
    return {1'b0, base + ofs};
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a[1:0] == 2'b00 && a < 12'h00C) shadow[a[3:2]] = d;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; e = reg_err;
  endtask

  task automatic xlate(input int w, input logic [31:0] ofs, input string tag);
    logic [32:0] ex;
    xl_req = 1'b1; xl_win = 2'(w); xl_ofs = ofs[27:0];
    ex = expect_xl(cfg_rv, w, ofs);
    @(negedge clk);
    xl_req = 1'b0;
    check({tag, " vld"}, {31'h0, xl_vld}, 32'h1);
    check({tag, " err"}, {31'h0, xl_err}, {31'h0, ex[32]});
    check({tag, " addr"}, xl_addr, ex[31:0]);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    check("R2 xl_vld", {31'h0, xl_vld}, 32'h0);
    check("R2 reg_err", {31'h0, reg_err}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      bus_read(12'(i * 4), d, e);
      check("R2 reset value", d, 32'h0);
    end
  endtask

  task automatic t_regs_rw;
    logic [31:0] d; logic e;
    for (int i = 0; i < 8; i++) bus_write(12'(i * 4), 32'hA500_0000 ^ (32'h0101_0101 * (i + 1)));
    for (int i = 0; i < 8; i++) begin
      bus_read(12'(i * 4), d, e);
      check("R1 readback", d, 32'hA500_0000 ^ (32'h0101_0101 * (i + 1)));
      check("R1 no err", {31'h0, e}, 32'h0);
    end
  endtask

  task automatic t_bad_access;
    logic [31:0] d; logic e;
    bus_write(12'h020, 32'hDEAD_BEEF);
    check("R3 wr err unlisted", {31'h0, reg_err}, 32'h1);
    bus_write(12'h006, 32'hDEAD_BEEF);
    check("R3 wr err misaligned", {31'h0, reg_err}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      bus_read(12'(i * 4), d, e);
      check("R3 unchanged", d, 32'hA500_0000 ^ (32'h0101_0101 * (i + 1)));
    end
    bus_read(12'h400, d, e);
    check("R3 rd zero", d, 32'h0);
    check("R3 rd err", {31'h0, e}, 32'h1);
    bus_read(12'h001, d, e);
    check("R3 rd misaligned zero", d, 32'h0);
    check("R3 rd misaligned err", {31'h0, e}, 32'h1);
  endtask

  task automatic t_nibble;
    cfg_rv = 1'b0;
    bus_write(12'h000, 32'hFFFF_FFF5);
    bus_write(12'h004, 32'h0000_000A);
    bus_write(12'h008, 32'h1234_567F);
    xlate(0, 32'h0012_3456, "R4 win0");
    xlate(1, 32'h0FFF_FFFF, "R4 win1 top");
    xlate(2, 32'h0000_0000, "R4 win2");
    xlate(0, 32'h0BFF_FFFF, "R6 vp win0 last");
    xlate(0, 32'h0C00_0000, "R6 vp win0 over");
  endtask

  task automatic t_masked;
    cfg_rv = 1'b1;
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h004, 32'hABCD_1234);
    bus_write(12'h008, 32'h8765_4321);
    xlate(0, 32'h00AB_CDEF, "R5 win0");
    xlate(1, 32'h0000_1234, "R5 win1");
    xlate(2, 32'h07FF_FFFF, "R5 win2 last");
    xlate(0, 32'h0100_0000, "R6 rv win0 over");
    xlate(1, 32'h0400_0000, "R6 rv win1 over");
    xlate(2, 32'h0800_0000, "R6 rv win2 over");
    xlate(3, 32'h0000_0000, "R7 idx3");
    cfg_rv = 1'b0;
    xlate(3, 32'h0000_0010, "R7 idx3 vp");
  endtask

  task automatic t_update_timing;
    cfg_rv = 1'b0;
    bus_write(12'h000, 32'h0000_0005);
    // write and request in the same cycle: old value applies
    reg_addr = 12'h000; reg_wdata = 32'h0000_0003; reg_wr = 1'b1;
    xl_req = 1'b1; xl_win = 2'd0; xl_ofs = 28'h10;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R8 same-cycle old", xl_addr, 32'h5000_0010);
    shadow[0] = 32'h0000_0003;
    // request held: the cycle after the write sees the new value
    @(negedge clk);
    xl_req = 1'b0;
    check("R8 next-cycle new", xl_addr, 32'h3000_0010);
    @(negedge clk);
    check("R8 idle no vld", {31'h0, xl_vld}, 32'h0);
  endtask

  task automatic t_other_regs;
    cfg_rv = 1'b1;
    bus_write(12'h004, 32'h5555_5555);
    xlate(1, 32'h0000_0100, "R9 before");
    for (int i = 3; i < 8; i++) bus_write(12'(i * 4), 32'hFFFF_FFFF);
    xlate(1, 32'h0000_0100, "R9 after");
    cfg_rv = 1'b0;
    xlate(1, 32'h0000_0100, "R9 after vp");
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs_rw();
    t_bad_access();
    t_nibble();
    t_masked();
    t_update_timing();
    t_other_regs();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule